// File: doc/BRIEF.md
# Port Overcurrent Fault Timer

This block decides when one powered port must be shut off because of excess output current. A power-up strobe arms it. It then moves through two phases. The first is a gate-ramp phase, in which the pass switch must report that it is fully on within a bounded number of time-base ticks. The second is a run phase, in which two independent checks watch the load.

The first run-phase check is a leaky accumulator. It rises by one per tick while the output current is above the cut threshold. While the current is below it, it falls by one every sixteenth tick and never drops below zero. The second check applies only to high-power loads: it times how long the current limiter stays engaged without a break.

Any of the three conditions raises a single-cycle fault pulse and drops the block back to its idle phase. In the idle phase the accumulator value stays visible for debug until the next power-up strobe. Comparators, threshold arithmetic and the time base are outside the block. The time base is delivered as a one-cycle tick, nominally one per millisecond.

Top module: `overload_fault_timer`

## Requirements
- R1: After reset, fault_o is 0 and tmr_o is 0. Until the first start_i, no tick or input combination changes either output.
- R2: start_i clears the accumulator and its down-count prescaler, clears both run counters, and enters the ramp phase. It takes priority over every other input in the same cycle.
- R3: In the run phase, each tick_i with over_cut_i high raises tmr_o by one. Ticks in the ramp phase leave tmr_o unchanged.
- R4: In the run phase, ticks with over_cut_i low advance a 4-bit prescaler. Every sixteenth such tick lowers tmr_o by one, and tmr_o never goes below zero. The prescaler is not cleared by up-count ticks.
- R5: A tick that brings tmr_o to CUT_LIMIT (default 60) sets fault_o high. The fault output is registered on that tick's clock edge, and it stays high for exactly one cycle.
- R6: In the run phase with plus_mode_i high, PLUS_LIMIT (default 15) consecutive ticks with ilim_act_i high raise a fault. A tick with ilim_act_i low restarts the count. With plus_mode_i low, ilim_act_i has no effect.
- R7: In the ramp phase, a tick with fet_on_i high moves the block to the run phase. INRUSH_LIMIT (default 75) ticks in the ramp phase without fet_on_i raise a fault.
- R8: After a fault, the block is idle. tmr_o holds its value and no further fault occurs until the next start_i.
- R9: Cycles without tick_i or start_i change neither tmr_o nor fault_o (fault_o returns to 0).
- R10: tmr_o never exceeds CUT_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base tick |
| over_cut_i | input | 1 | Output current above the cut threshold |
| ilim_act_i | input | 1 | Current limiter engaged |
| plus_mode_i | input | 1 | High-power load granted |
| fet_on_i | input | 1 | Pass switch fully on |
| start_i | input | 1 | Power-up start strobe |
| fault_o | output | 1 | One-cycle shutdown pulse |
| tmr_o | output | $clog2(CUT_LIMIT+1) | Leaky accumulator value |

## Verification
The bench builds the block with its default limits: 60 for the cut timeout, 15 for the limiter run, 75 for the ramp window and a 16-to-1 down-count divider. At these values, every window boundary fits in a short directed run. This covers the last tick before each fault and the tick that raises it, the prescaler's sixteenth-tick step, the zero floor and the saturated hold after a cut fault. A seeded random phase then varies the over-current and limiter densities from segment to segment, so runs of the accumulator that rise, hover and decay are all compared against a bench model.

// File: rtl/ovt_pkg.sv
// Shared types for the overcurrent fault timer.
// Assumes: nothing beyond IEEE 1800-2017.
package ovt_pkg;

    // Port phase: idle, gate ramp, normal run
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_RAMP = 2'd1,
        PH_RUN  = 2'd2
    } phase_t;

endpackage

// File: rtl/ovt_leaky_acc.sv
// Leaky accumulator: rises one per over-threshold step, falls one per
// 2**DIV_LOG2 under-threshold steps, floor at zero, saturates at LIMIT.
// Assumes step_i is a single-cycle qualifier and clr_i wins over step_i.
module ovt_leaky_acc #(
    parameter  int LIMIT    = 60,
    parameter  int DIV_LOG2 = 4,
    localparam int AW       = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          step_i,
    input  logic          over_i,
    output logic [AW-1:0] acc_o,
    output logic          hit_o
);

    localparam logic [AW-1:0] LIM = AW'(LIMIT);

    logic [AW-1:0] acc_q;
    logic          dec_en;

    generate
        if (DIV_LOG2 > 0) begin : g_pre
            logic [DIV_LOG2-1:0] pre_q;
            // Prescaler: counts under-threshold steps only
            always_ff @(posedge clk) begin
                if (!rst_n)                  pre_q <= '0;
                else if (clr_i)              pre_q <= '0;
                else if (step_i && !over_i)  pre_q <= pre_q + 1'b1;
            end
            assign dec_en = step_i && !over_i && (&pre_q);
        end else begin : g_nopre
            assign dec_en = step_i && !over_i;
        end
    endgenerate

    assign hit_o = step_i && over_i && (acc_q >= LIM - 1'b1);
    assign acc_o = acc_q;

    // Accumulator: saturating up-count, floored down-count
    always_ff @(posedge clk) begin
        if (!rst_n)                         acc_q <= '0;
        else if (clr_i)                     acc_q <= '0;
        else if (step_i && over_i) begin
            if (acc_q < LIM)                acc_q <= acc_q + 1'b1;
        end else if (dec_en && acc_q != '0) acc_q <= acc_q - 1'b1;
    end

endmodule

// File: rtl/ovt_run_counter.sv
// Consecutive-run counter: counts steps with cond_i high, restarts on a
// step with cond_i low, flags the step that completes LIMIT in a row.
// Assumes LIMIT >= 1 and that clr_i wins over step_i.
module ovt_run_counter #(
    parameter  int LIMIT = 15,
    localparam int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    input  logic cond_i,
    output logic hit_o
);

    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    assign hit_o = step_i && cond_i && (cnt_q >= LIM - 1'b1);

    // Run length register
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clr_i)        cnt_q <= '0;
        else if (step_i) begin
            if (!cond_i)       cnt_q <= '0;
            else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/overload_fault_timer.sv
// Overcurrent fault timer for one port. start_i arms a gate-ramp window,
// then the run phase watches a leaky cut-threshold accumulator and a
// high-power limiter run. Any trip gives a one-cycle fault and idles.
// Assumes tick_i is a one-cycle pulse and inputs are synchronous to clk.
module overload_fault_timer
    import ovt_pkg::*;
#(
    parameter  int CUT_LIMIT    = 60,
    parameter  int PLUS_LIMIT   = 15,
    parameter  int INRUSH_LIMIT = 75,
    parameter  int DIV_LOG2     = 4,
    localparam int TMR_W        = $clog2(CUT_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             over_cut_i,
    input  logic             ilim_act_i,
    input  logic             plus_mode_i,
    input  logic             fet_on_i,
    input  logic             start_i,
    output logic             fault_o,
    output logic [TMR_W-1:0] tmr_o
);

    phase_t phase_q;
    logic   ramp_step, run_step;
    logic   inr_hit, cut_hit, plus_hit, trip;
    logic   fault_q;

    assign ramp_step = tick_i && !start_i && (phase_q == PH_RAMP);
    assign run_step  = tick_i && !start_i && (phase_q == PH_RUN);

    ovt_run_counter #(.LIMIT(INRUSH_LIMIT)) u_inrush (
        .clk(clk), .rst_n(rst_n), .clr_i(start_i),
        .step_i(ramp_step), .cond_i(!fet_on_i), .hit_o(inr_hit)
    );

    ovt_leaky_acc #(.LIMIT(CUT_LIMIT), .DIV_LOG2(DIV_LOG2)) u_leaky (
        .clk(clk), .rst_n(rst_n), .clr_i(start_i),
        .step_i(run_step), .over_i(over_cut_i),
        .acc_o(tmr_o), .hit_o(cut_hit)
    );

    ovt_run_counter #(.LIMIT(PLUS_LIMIT)) u_plus (
        .clk(clk), .rst_n(rst_n), .clr_i(start_i),
        .step_i(run_step), .cond_i(plus_mode_i && ilim_act_i),
        .hit_o(plus_hit)
    );

    assign trip = inr_hit || cut_hit || plus_hit;

    // Phase sequencing: arm, ramp to run, drop to idle on trip
    always_ff @(posedge clk) begin
        if (!rst_n)                       phase_q <= PH_OFF;
        else if (start_i)                 phase_q <= PH_RAMP;
        else if (trip)                    phase_q <= PH_OFF;
        else if (ramp_step && fet_on_i)   phase_q <= PH_RUN;
    end

    // Fault pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= trip && !start_i;
    end

    assign fault_o = fault_q;

endmodule

// File: rtl/ovt_checker.sv
// Property checker for overload_fault_timer, bound to every instance.
// Assumes the phase encoding of ovt_pkg.
module ovt_checker
    import ovt_pkg::*;
#(
    parameter int CUT_LIMIT = 60,
    parameter int TMR_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             over_cut_i,
    input logic             start_i,
    input logic             fault_o,
    input logic [TMR_W-1:0] tmr_o,
    input phase_t           phase_i
);

    localparam logic [TMR_W-1:0] LIM = TMR_W'(CUT_LIMIT);

    // R5
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o);

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_o <= LIM);

    // R9
    idle_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !start_i) |=> ($stable(tmr_o) && !fault_o));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tmr_o == '0 && phase_i == PH_RAMP && !fault_o));

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && over_cut_i && !start_i && phase_i == PH_RUN && tmr_o < LIM)
        |=> (tmr_o == TMR_W'($past(tmr_o) + 1'b1)));

    // R4
    no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !over_cut_i && !start_i) |=> (tmr_o <= $past(tmr_o)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_OFF && !start_i) |=> ($stable(tmr_o) && !fault_o));

    // R7
    ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_RAMP && !start_i) |=> $stable(tmr_o));

endmodule

bind overload_fault_timer ovt_checker #(
    .CUT_LIMIT(CUT_LIMIT), .TMR_W(TMR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .over_cut_i(over_cut_i),
    .start_i(start_i), .fault_o(fault_o), .tmr_o(tmr_o), .phase_i(phase_q)
);

// File: tb/overload_fault_timer_tb.sv
`timescale 1ns/1ps
module overload_fault_timer_tb;

    localparam int CUT  = 60;
    localparam int PLUS = 15;
    localparam int INR  = 75;
    localparam int TW   = $clog2(CUT + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, over = 0, ilim = 0, plus = 0, fet = 0, start = 0;
    logic fault;
    logic [TW-1:0] tmr;

    always #2.5 clk = ~clk;

    overload_fault_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .over_cut_i(over),
        .ilim_act_i(ilim), .plus_mode_i(plus), .fet_on_i(fet),
        .start_i(start), .fault_o(fault), .tmr_o(tmr)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model (0 idle, 1 ramp, 2 run)
    int m_phase = 0, m_acc = 0, m_pre = 0, m_inr = 0, m_plus = 0;
    bit m_fault = 0;

    function automatic void model_step();
        bit trip;
        trip = 0;
        if (!rst_n) begin
            m_phase = 0; m_acc = 0; m_pre = 0; m_inr = 0; m_plus = 0; m_fault = 0;
        end else if (start) begin
            m_phase = 1; m_acc = 0; m_pre = 0; m_inr = 0; m_plus = 0; m_fault = 0;
        end else begin
            if (tick && m_phase == 1) begin
                if (fet) m_phase = 2;
                else if (m_inr + 1 >= INR) trip = 1;
                else m_inr++;
            end else if (tick && m_phase == 2) begin
                if (over) begin
                    if (m_acc + 1 >= CUT) trip = 1;
                    m_acc = (m_acc + 1 > CUT) ? CUT : m_acc + 1;
                end else begin
                    if (m_pre == 15) begin
                        m_pre = 0;
                        if (m_acc > 0) m_acc--;
                    end else m_pre++;
                end
                if (plus && ilim) begin
                    if (m_plus + 1 >= PLUS) trip = 1;
                    else m_plus++;
                end else m_plus = 0;
            end
            m_fault = trip;
            if (trip) m_phase = 0;
        end
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(bit t, bit o, bit il, bit pl, bit f, bit st);
        tick = t; over = o; ilim = il; plus = pl; fet = f; start = st;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(cur_req, "fault", int'(fault), int'(m_fault));
        check(cur_req, "tmr", int'(tmr), m_acc);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int p_over, p_ilim;
        seed = $urandom(32'h5EED_0461);
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0);
        check("R1", "reset tmr", int'(tmr), 0);
        check("R1", "reset fault", int'(fault), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) cyc(1, 1, 1, 1, 1, 0);
        check("R1", "tmr before start", int'(tmr), 0);

        // R3 up-count, R7 ramp exit
        cur_req = "R2"; cyc(0, 0, 0, 0, 0, 1);
        cur_req = "R3";
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0, 0);
        check("R3", "ramp ticks ignore over", int'(tmr), 0);
        cur_req = "R7"; cyc(1, 0, 0, 0, 1, 0);
        cur_req = "R3";
        for (int i = 0; i < 10; i++) cyc(1, 1, 0, 0, 0, 0);
        check("R3", "up count", int'(tmr), 10);

        // R4 prescaled decay
        cur_req = "R4";
        for (int i = 0; i < 15; i++) cyc(1, 0, 0, 0, 0, 0);
        check("R4", "15 down ticks", int'(tmr), 10);
        cyc(1, 0, 0, 0, 0, 0);
        check("R4", "16th down tick", int'(tmr), 9);
        for (int i = 0; i < 16; i++) cyc(1, 0, 0, 0, 0, 0);
        check("R4", "32nd down tick", int'(tmr), 8);

        // R2 clear on start
        cur_req = "R2"; cyc(1, 1, 0, 0, 1, 1);
        check("R2", "start clears", int'(tmr), 0);

        // R4 floor at zero
        cur_req = "R4"; cyc(1, 0, 0, 0, 1, 0);
        for (int i = 0; i < 40; i++) cyc(1, 0, 0, 0, 0, 0);
        check("R4", "floor", int'(tmr), 0);

        // R9 non-tick cycles
        cur_req = "R2"; cyc(0, 0, 0, 0, 0, 1);
        cur_req = "R9"; cyc(1, 0, 0, 0, 1, 0);
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) cyc(0, 1, 1, 1, 0, 0);
        check("R9", "no tick hold", int'(tmr), 5);

        // R5 cut timeout, R8/R10 hold afterwards
        cur_req = "R5";
        for (int i = 0; i < 54; i++) cyc(1, 1, 0, 0, 0, 0);
        check("R5", "no fault at 59", int'(fault), 0);
        cyc(1, 1, 0, 0, 0, 0);
        check("R5", "fault at 60", int'(fault), 1);
        cyc(0, 0, 0, 0, 0, 0);
        check("R5", "one-cycle pulse", int'(fault), 0);
        cur_req = "R8";
        for (int i = 0; i < 10; i++) cyc(1, 1, 1, 1, 0, 0);
        check("R8", "idle hold", int'(tmr), 60);
        check("R10", "saturated value", int'(tmr), CUT);

        // R6 high-power limiter run
        cur_req = "R6"; cyc(0, 0, 0, 0, 0, 1); cyc(1, 0, 0, 0, 1, 0);
        for (int i = 0; i < 14; i++) cyc(1, 0, 1, 1, 0, 0);
        cyc(1, 0, 0, 1, 0, 0);
        for (int i = 0; i < 14; i++) cyc(1, 0, 1, 1, 0, 0);
        check("R6", "broken run no fault", int'(fault), 0);
        cyc(1, 0, 1, 1, 0, 0);
        check("R6", "fault at 15th", int'(fault), 1);
        cyc(0, 0, 0, 0, 0, 1); cyc(1, 0, 0, 0, 1, 0);
        for (int i = 0; i < 30; i++) cyc(1, 0, 1, 0, 0, 0);
        check("R6", "ignored without plus mode", int'(fault), 0);

        // R7 gate-ramp window
        cur_req = "R7"; cyc(0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 74; i++) cyc(1, 0, 0, 0, 0, 0);
        check("R7", "no fault at 74", int'(fault), 0);
        cyc(1, 0, 0, 0, 0, 0);
        check("R7", "fault at 75", int'(fault), 1);
        cyc(0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 74; i++) cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 1, 0);
        check("R7", "late fet on", int'(fault), 0);
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, 0);
        check("R7", "run after ramp", int'(tmr), 3);

        // Random phase against the model
        cur_req = "R4";
        p_over = 50; p_ilim = 50;
        for (int i = 0; i < 6000; i++) begin
            bit st;
            if (i % 300 == 0) begin
                case ($urandom % 3)
                    0: p_over = 15;
                    1: p_over = 50;
                    default: p_over = 85;
                endcase
                p_ilim = ($urandom % 2) ? 95 : 40;
            end
            st = (m_phase == 0) ? ($urandom % 20 == 0) : ($urandom % 700 == 0);
            cyc($urandom % 4 != 0, ($urandom % 100) < p_over, ($urandom % 100) < p_ilim,
                $urandom % 2, $urandom % 40 == 0, st);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule